// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block guards a processor against lockups. A prescaler halves the system clock and feeds a binary counter (22 stages by default). A 2-bit period field picks one of four taps, spaced by factors of four. When the lower bits up to that tap roll over, the block sends a one-cycle non-maskable interrupt request. If the reset-link bit is set, it also holds an internal reset request for a fixed number of cycles. The external reset pad is never driven.

Software controls the block through a narrow write port that has two registers.

- **Mode register (address 0):** holds the enable bit, the period field and the reset-link bit.
- **Command register (address 1):** accepts only two key bytes. 0x4E restarts the count. 0xB1 stops the watchdog, but only if the enable bit was cleared beforehand.

Every other command byte is discarded. Clearing the enable bit alone does not stop the timer. Stopping it always takes two deliberate writes.

Top module: `wdog_keyed`

## Requirements
- R1: After reset the watchdog runs with period field 0 and reset-link 0, and both `nmi_req` and `sys_rst_req` are low.
- R2: The mode register at address 0 has these fields: bit 0 = enable, bits 2:1 = period select, bit 3 = reset-link. While running, the counter advances once every two clocks. A timeout occurs after 2^(TAP_LO+2*period) advances, which is 2^(TAP_LO+2*period+1) clocks after a clear.
- R3: `nmi_req` is high for exactly one cycle per timeout. Without a clear, timeouts repeat with the same spacing.
- R4: Writing 0x4E to the command register (address 1) clears the counter and the prescaler phase, so the next timeout is a full period later.
- R5: Any other byte written to the command register has no effect. A write to any address other than 0 or 1 also has no effect.
- R6: Writing the mode register with enable = 0, and writing nothing else, leaves the watchdog counting and timing out.
- R7: Writing 0xB1 while enable = 0 stops the watchdog, and the counter holds its value. A later mode write with enable = 1 resumes counting from the held value.
- R8: Writing 0xB1 while enable = 1 has no effect.
- R9: With reset-link = 1, each timeout also raises `sys_rst_req` for RST_HOLD (8) cycles, starting in the same cycle as `nmi_req`. With reset-link = 0, `sys_rst_req` stays low.
- R10: If a 0x4E write lands in the same cycle as a timeout, the clear wins. No `nmi_req` and no `sys_rst_req` is produced for that timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W (2) | Register address: 0 = mode, 1 = command |
| wr_data | input | 8 | Write data |
| nmi_req | output | 1 | One-cycle non-maskable interrupt request |
| sys_rst_req | output | 1 | Internal reset request, held RST_HOLD cycles |

## Verification
The two functions that can fall in the same clock edge are a key-byte clear and a tap rollover. The bench counts clocks from a clear. It then times a second 0x4E write so that the write is sampled on exactly the edge where the rollover would occur. The case is judged a pass when neither request appears on that edge or on any later one, and the next interrupt comes one full period after the late clear. The reset-link bit is set during this test, so a leaked reset request would also be caught.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam logic [7:0] KEY_RESTART = 8'h4E;
  localparam logic [7:0] KEY_DISARM  = 8'hB1;

  // bit 3 reset-link, bits 2:1 period select, bit 0 enable
  typedef struct packed {
    logic       rst_link;
    logic [1:0] period;
    logic       enable;
  } mode_t;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int ADDR_W    = 2,
  parameter int MODE_ADDR = 0,
  parameter int CMD_ADDR  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output mode_t             mode,
  output logic              running,
  output logic              restart
);
  localparam logic [ADDR_W-1:0] MODE_A = ADDR_W'(MODE_ADDR);
  localparam logic [ADDR_W-1:0] CMD_A  = ADDR_W'(CMD_ADDR);

  mode_t mode_q, mode_d;
  logic  run_q, run_d;
  logic  mode_wr, cmd_wr, disarm;

  assign mode_wr = wr_en && (wr_addr == MODE_A);
  assign cmd_wr  = wr_en && (wr_addr == CMD_A);
  assign restart = cmd_wr && (wr_data == KEY_RESTART);
  assign disarm  = cmd_wr && (wr_data == KEY_DISARM) && !mode_q.enable;

  always_comb begin
    mode_d = mode_q;
    run_d  = run_q;
    if (mode_wr) begin
      mode_d = mode_t'(wr_data[3:0]);
      if (wr_data[0]) run_d = 1'b1;
    end
    if (disarm) run_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '{rst_link: 1'b0, period: 2'd0, enable: 1'b1};
      run_q  <= 1'b1;
    end else begin
      mode_q <= mode_d;
      run_q  <= run_d;
    end
  end

  assign mode    = mode_q;
  assign running = run_q;

  // R7/R8: the watchdog only stops after a disarm key with enable already low
  assert_stop_needs_key_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run_q) |-> $past(cmd_wr && wr_data == KEY_DISARM && !mode_q.enable));
  // R6: clearing the enable bit alone never stops the watchdog
  assert_enable_clear_runs_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && mode_wr && !wr_data[0]) |=> run_q);
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int CNT_W  = 22,
  parameter int TAP_LO = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       running,
  input  logic       restart,
  input  logic [1:0] period,
  output logic       timeout
);
  localparam int NUM_TAPS = 4;
  localparam int TOP_TAP  = TAP_LO + 2 * (NUM_TAPS - 1);

  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic                half_q, half_d;
  logic                advance;
  logic [NUM_TAPS-1:0] tap_full;

  initial begin
    if (TAP_LO < 1 || TOP_TAP > CNT_W) $error("wdog_counter: taps outside counter");
  end

  for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
    assign tap_full[g] = &cnt_q[TAP_LO+2*g-1:0];
  end

  assign advance = running && half_q;
  assign timeout = advance && tap_full[period] && !restart;

  always_comb begin
    cnt_d  = cnt_q;
    half_d = half_q;
    if (restart) begin
      cnt_d  = '0;
      half_d = 1'b0;
    end else if (running) begin
      half_d = !half_q;
      if (half_q) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      half_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      half_q <= half_d;
    end
  end

  // R4: a restart key leaves the count at zero
  assert_restart_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0));
  // R7: a stopped watchdog holds its count
  assert_hold_when_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !restart) |=> $stable(cnt_q));
  // R3: timeouts are never back to back
  assert_timeout_spaced_R3: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |=> !timeout);
endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
  parameter int RST_HOLD = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic timeout,
  input  logic rst_link,
  output logic nmi_req,
  output logic sys_rst_req
);
  localparam int HOLD_W = $clog2(RST_HOLD + 1);

  logic              nmi_q, nmi_d;
  logic [HOLD_W-1:0] hold_q, hold_d;

  always_comb begin
    nmi_d  = timeout;
    hold_d = hold_q;
    if (timeout && rst_link)  hold_d = HOLD_W'(RST_HOLD);
    else if (hold_q != '0)    hold_d = hold_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_q  <= 1'b0;
      hold_q <= '0;
    end else begin
      nmi_q  <= nmi_d;
      hold_q <= hold_d;
    end
  end

  assign nmi_req     = nmi_q;
  assign sys_rst_req = (hold_q != '0);

  // R9: a reset request only starts together with an interrupt request
  assert_rst_with_nmi_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_req) |-> nmi_req);
  // R9: without the link bit a timeout never starts a reset request
  assert_no_link_no_rst_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout && !rst_link && !sys_rst_req) |=> !sys_rst_req);
  // R3: interrupt request lasts one cycle
  assert_nmi_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_req |=> !nmi_req);
endmodule

// File: rtl/wdog_keyed.sv
module wdog_keyed
  import wdog_pkg::*;
#(
  parameter int ADDR_W   = 2,
  parameter int CNT_W    = 22,
  parameter int TAP_LO   = 15,
  parameter int RST_HOLD = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic              nmi_req,
  output logic              sys_rst_req
);
  logic [1:0] rst_sync_q;
  logic       rst_n_int;
  mode_t      mode;
  logic       running, restart, timeout;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  wdog_regs #(.ADDR_W(ADDR_W), .MODE_ADDR(0), .CMD_ADDR(1)) regs_i (
    .clk(clk), .rst_n(rst_n_int), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .mode(mode), .running(running), .restart(restart)
  );

  wdog_counter #(.CNT_W(CNT_W), .TAP_LO(TAP_LO)) cnt_i (
    .clk(clk), .rst_n(rst_n_int), .running(running), .restart(restart),
    .period(mode.period), .timeout(timeout)
  );

  wdog_pulse #(.RST_HOLD(RST_HOLD)) pulse_i (
    .clk(clk), .rst_n(rst_n_int), .timeout(timeout), .rst_link(mode.rst_link),
    .nmi_req(nmi_req), .sys_rst_req(sys_rst_req)
  );

  // R10: a restart in the timeout cycle suppresses the interrupt
  assert_restart_wins_R10: assert property (@(posedge clk) disable iff (!rst_n_int)
    restart |=> !nmi_req);
  // R1: nothing is requested in the first cycle after reset
  assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n_int)
    $rose(rst_n_int) |-> (!nmi_req && !sys_rst_req));
endmodule

// File: tb/wdog_keyed_tb.sv
module wdog_keyed_tb_top;
  localparam int TAP_LO = 3;
  localparam int HOLD   = 8;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [1:0] wr_addr;
  logic [7:0] wr_data;
  logic       nmi_req, sys_rst_req;

  int checks = 0, errors = 0;
  int since = 0;
  int first_nmi = -1;
  int rst_seen = 0;
  bit done = 0;

  always #5 clk = ~clk;

  wdog_keyed #(.ADDR_W(2), .CNT_W(10), .TAP_LO(TAP_LO), .RST_HOLD(HOLD)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .nmi_req(nmi_req), .sys_rst_req(sys_rst_req)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    since++;
    if (nmi_req && first_nmi < 0) first_nmi = since;
    if (sys_rst_req) rst_seen++;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic restart();
    wr(2'd1, 8'h4E);
    since = 0; first_nmi = -1; rst_seen = 0;
  endtask

  task automatic set_mode(bit en, int per, bit link);
    wr(2'd0, {4'h0, link, 2'(per), en});
  endtask

  function automatic int period_clks(int per);
    return 1 << (TAP_LO + 2 * per + 1);
  endfunction

  task automatic wait_nmi(int limit);
    while (first_nmi < 0 && since < limit) tick();
  endtask

  task automatic t_reset();
    check("R1 nmi after reset", nmi_req, 0);
    check("R1 rst after reset", sys_rst_req, 0);
    restart();
    wait_nmi(period_clks(0) + 4);
    check("R1 default period", first_nmi, period_clks(0));
  endtask

  task automatic t_periods();
    for (int p = 0; p < 4; p++) begin
      set_mode(1, p, 0);
      restart();
      wait_nmi(period_clks(p) + 4);
      check("R2 timeout spacing", first_nmi, period_clks(p));
      check("R9 no reset without link", rst_seen, 0);
    end
  endtask

  task automatic t_repeat();
    set_mode(1, 1, 0);
    restart();
    wait_nmi(period_clks(1) + 4);
    tick();
    check("R3 pulse one cycle", nmi_req, 0);
    since = 0; first_nmi = -1;
    wait_nmi(period_clks(1) + 4);
    check("R3 repeat spacing", first_nmi, period_clks(1) - 1);
  endtask

  task automatic t_kick();
    set_mode(1, 0, 0);
    restart();
    for (int i = 0; i < 8; i++) begin
      idle(10);
      wr(2'd1, 8'h4E);
      if (first_nmi >= 0) break;
    end
    check("R4 restart keeps nmi away", first_nmi, -1);
    first_nmi = -1;
  endtask

  task automatic t_junk();
    restart();
    wr(2'd1, 8'h00);
    wr(2'd1, 8'h4F);
    wr(2'd2, 8'h4E);
    wr(2'd3, 8'hB1);
    wait_nmi(period_clks(0) + 4);
    check("R5 other keys ignored", first_nmi, period_clks(0));
  endtask

  task automatic t_enable_only();
    set_mode(0, 0, 0);
    restart();
    wait_nmi(period_clks(0) + 4);
    check("R6 enable clear alone keeps running", first_nmi, period_clks(0));
    set_mode(1, 0, 0);
  endtask

  task automatic t_disarm();
    set_mode(1, 0, 0);
    restart();
    idle(5);
    set_mode(0, 0, 0);
    wr(2'd1, 8'hB1);
    idle(60);
    check("R7 stopped no nmi", first_nmi, -1);
    set_mode(1, 0, 0);
    since = 0;
    wait_nmi(40);
    check("R7 resume from held count", first_nmi, period_clks(0) - 7);
  endtask

  task automatic t_b1_enabled();
    set_mode(1, 0, 0);
    restart();
    wr(2'd1, 8'hB1);
    wait_nmi(period_clks(0) + 4);
    check("R8 disarm ignored while enabled", first_nmi, period_clks(0));
  endtask

  task automatic t_link();
    int w;
    set_mode(1, 0, 1);
    restart();
    wait_nmi(period_clks(0) + 4);
    check("R9 nmi with link", first_nmi, period_clks(0));
    check("R9 rst starts with nmi", sys_rst_req, 1);
    w = 1;
    while (w < 20) begin
      tick();
      if (!sys_rst_req) break;
      w++;
    end
    check("R9 reset width", w, HOLD);
  endtask

  task automatic t_collide();
    set_mode(1, 0, 1);
    restart();
    idle(period_clks(0) - 1);
    wr(2'd1, 8'h4E);
    check("R10 no nmi on collision", first_nmi, -1);
    check("R10 no reset on collision", rst_seen, 0);
    since = 0;
    wait_nmi(period_clks(0) + 4);
    check("R10 full period after late restart", first_nmi, period_clks(0));
    idle(HOLD + 2);
    set_mode(1, 0, 0);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: bench timed out");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_periods();
    t_repeat();
    t_kick();
    t_junk();
    t_enable_only();
    t_disarm();
    t_b1_enabled();
    t_link();
    t_collide();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule